// File: doc/BRIEF.md
# Highest-Priority Pending Interrupt Scanner

This block walks a range of interrupt IDs, one ID per clock, and keeps a record for each CPU of the most urgent interrupt that is pending for it. The record holds the interrupt ID, an 8-bit priority, an NMI flag and a valid flag. For each ID the block presents `scan_id`. The surrounding logic answers in the same cycle with that interrupt's programmed priority, NMI bit, security group bit and target CPU. Pending status arrives as 32-bit eligibility words. The block asks for a new word with `mask_fetch` and uses bit `scan_id % 32` of it.

A full rescan clears every record and walks all IDs. An incremental rescan walks only `range_lo..range_hi` (inclusive, with `range_lo <= range_hi < NUM_IRQ`) and starts from the published records. After the walk, each CPU's externally supplied LPI candidate is compared in one extra cycle. One more cycle then decides the outcome. Either the results are published with a one-cycle `done` pulse, or, if the old best of some CPU may have lost its standing, the block switches to a full rescan.

Top module: `hppi_scanner`

## Requirements
- R1: A candidate replaces the current best of its CPU when its effective priority is numerically lower.
- R2: At equal effective priority, an NMI candidate replaces a non-NMI best, and a non-NMI candidate never replaces an NMI best.
- R3: At equal priority and equal NMI status, the lower interrupt ID wins. A candidate whose ID equals the current best's ID also replaces it.
- R4: A non-NMI interrupt uses its programmed priority byte. An NMI uses 0x80 when `sec_disable` is 0 and its group bit is 1, and 0x00 in every other case.
- R5: A priority of 0xFF means "nothing pending", and `best_valid` is 0 exactly then. A full rescan sets every working priority to 0xFF and clears the NMI flags before it walks the IDs.
- R6: `mask_fetch` is high while the scan is on the range start and on every ID that is a multiple of 32. The word on `mask_in` in that cycle is used and held for the following IDs.
- R7: An eligible interrupt whose target is flagged invalid, or names an index of `NUM_CPU` or more, is not recorded for any CPU.
- R8: After an incremental walk, a CPU whose best was not replaced, whose best is valid, and whose best ID lies inside the walked range forces a full rescan before completion. Otherwise the incremental result is final.
- R9: A CPU's LPI candidate is compared only when its `lpi_enable` bit is 1, `grp1ns_en` is 1 and the candidate priority is not 0xFF.
- R10: One ID is examined per cycle, so `done` rises NUM_IRQ+2 cycles after a full start, or (hi-lo+1)+2 cycles after an incremental start, plus NUM_IRQ+2 more on a fallback. `done` lasts one cycle. The published outputs change only when `done` rises. `start` while `busy` is ignored.
- R11: After reset, `busy` and `done` are 0, every `best_prio` is 0xFF and every `best_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a scan (sampled while idle) |
| full_req | input | 1 | 1: full rescan, 0: incremental rescan of the range |
| range_lo | input | ID_W | First ID of an incremental range |
| range_hi | input | ID_W | Last ID of an incremental range |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| scan_id | output | ID_W | ID being examined |
| mask_fetch | output | 1 | `mask_in` is sampled this cycle |
| mask_in | input | 32 | Eligibility word for the 32-ID chunk holding `scan_id` |
| prio_in | input | 8 | Programmed priority of `scan_id` |
| nmi_in | input | 1 | NMI bit of `scan_id` |
| group_in | input | 1 | Group bit of `scan_id` |
| tgt_in | input | CPU_W | Target CPU index of `scan_id` |
| tgt_valid_in | input | 1 | Target index is meaningful |
| sec_disable | input | 1 | Security disabled |
| grp1ns_en | input | 1 | Non-secure group 1 enabled |
| lpi_enable | input | NUM_CPU | Per-CPU LPI enable |
| lpi_id | input | NUM_CPU*ID_W | Per-CPU LPI candidate ID |
| lpi_prio | input | NUM_CPU*8 | Per-CPU LPI candidate priority |
| lpi_nmi | input | NUM_CPU | Per-CPU LPI candidate NMI flag |
| best_id | output | NUM_CPU*ID_W | Published best ID per CPU |
| best_prio | output | NUM_CPU*8 | Published best priority per CPU |
| best_nmi | output | NUM_CPU | Published best NMI flag per CPU |
| best_valid | output | NUM_CPU | Published best is a real interrupt |

## Verification
Directed patterns each isolate one rule of the comparison. Two pending IDs with different priorities show the priority order. Equal priorities at different IDs show the ID tie-break. An NMI at the same effective priority as a plain interrupt shows the NMI preference. NMIs under each group and security setting show the synthesised priority. Untargeted interrupts, gated LPI candidates and an incremental range that drops the old best separate skipping, LPI gating and the fallback to a full rescan. A sweep of some hundreds of randomly configured full and incremental scans, spread over three CPUs and checked against an arithmetic model, also covers cycle counts and mask fetch counts.

// File: rtl/hppi_pkg.sv
// Shared types and constants for the pending-interrupt scanner.
package hppi_pkg;
    localparam int PRIO_W = 8;
    localparam logic [PRIO_W-1:0] PRIO_NONE   = 8'hFF;
    localparam logic [PRIO_W-1:0] PRIO_NMI_NS = 8'h80;
    localparam logic [PRIO_W-1:0] PRIO_NMI_S  = 8'h00;
    localparam int CHUNK_W = 32;
    localparam int CHUNK_B = 5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_LPI,
        ST_CHECK
    } scan_state_e;
endpackage

// File: rtl/hppi_prio_eval.sv
// Effective priority of one interrupt.
// NMIs get a synthesised priority; others pass their programmed byte.
// Assumes: purely combinational, inputs describe the interrupt under scan.
module hppi_prio_eval
    import hppi_pkg::*;
(
    input  logic [PRIO_W-1:0] prio,
    input  logic              nmi,
    input  logic              group_bit,
    input  logic              sec_disable,
    output logic [PRIO_W-1:0] eff_prio
);
    // Pick the synthesised or programmed priority.
    always_comb begin
        if (nmi) begin
            eff_prio = (!sec_disable && group_bit) ? PRIO_NMI_NS : PRIO_NMI_S;
        end else begin
            eff_prio = prio;
        end
    end
endmodule

// File: rtl/hppi_better.sv
// Decides whether a candidate should replace the recorded best.
// Order: numeric priority, then NMI, then lowest ID (equal ID counts as better).
// Assumes: purely combinational.
module hppi_better
    import hppi_pkg::*;
#(
    parameter int ID_W = 6
) (
    input  logic [ID_W-1:0]   cand_id,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic              cand_nmi,
    input  logic [ID_W-1:0]   best_id,
    input  logic [PRIO_W-1:0] best_prio,
    input  logic              best_nmi,
    output logic              take
);
    // Three-level comparison.
    always_comb begin
        if (cand_prio != best_prio) begin
            take = cand_prio < best_prio;
        end else if (cand_nmi != best_nmi) begin
            take = cand_nmi;
        end else begin
            take = cand_id <= best_id;
        end
    end
endmodule

// File: rtl/hppi_cpu_slot.sv
// Per-CPU record: a working best that is updated during a scan and a
// published best that is copied from it at completion.
// Assumes: at most one of init_full / init_incr / update source per cycle.
module hppi_cpu_slot
    import hppi_pkg::*;
#(
    parameter int ID_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_full,
    input  logic              init_incr,
    input  logic              cand_en,
    input  logic [ID_W-1:0]   cand_id,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic              cand_nmi,
    input  logic              lpi_step,
    input  logic              lpi_ok,
    input  logic [ID_W-1:0]   lpi_id,
    input  logic [PRIO_W-1:0] lpi_prio,
    input  logic              lpi_nmi,
    input  logic [ID_W-1:0]   range_lo,
    input  logic [ID_W-1:0]   range_hi,
    input  logic              publish,
    output logic              need_full,
    output logic [ID_W-1:0]   pub_id,
    output logic [PRIO_W-1:0] pub_prio,
    output logic              pub_nmi
);
    logic [ID_W-1:0]   w_id;
    logic [PRIO_W-1:0] w_prio;
    logic              w_nmi;
    logic              w_seen;
    logic [ID_W-1:0]   c_id;
    logic [PRIO_W-1:0] c_prio;
    logic              c_nmi;
    logic              c_en;
    logic              take;

    // Select the scan candidate or the LPI candidate.
    always_comb begin
        c_en   = lpi_step ? lpi_ok   : cand_en;
        c_id   = lpi_step ? lpi_id   : cand_id;
        c_prio = lpi_step ? lpi_prio : cand_prio;
        c_nmi  = lpi_step ? lpi_nmi  : cand_nmi;
    end

    hppi_better #(.ID_W(ID_W)) u_cmp (
        .cand_id   (c_id),
        .cand_prio (c_prio),
        .cand_nmi  (c_nmi),
        .best_id   (w_id),
        .best_prio (w_prio),
        .best_nmi  (w_nmi),
        .take      (take)
    );

    // Working record: clear, reload from published, or take a better candidate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_id   <= '0;
            w_prio <= PRIO_NONE;
            w_nmi  <= 1'b0;
            w_seen <= 1'b0;
        end else if (init_full) begin
            w_prio <= PRIO_NONE;
            w_nmi  <= 1'b0;
            w_seen <= 1'b0;
        end else if (init_incr) begin
            w_id   <= pub_id;
            w_prio <= pub_prio;
            w_nmi  <= pub_nmi;
            w_seen <= 1'b0;
        end else if (c_en && take) begin
            w_id   <= c_id;
            w_prio <= c_prio;
            w_nmi  <= c_nmi;
            w_seen <= 1'b1;
        end
    end

    // Published record: follows the working record only at completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pub_id   <= '0;
            pub_prio <= PRIO_NONE;
            pub_nmi  <= 1'b0;
        end else if (publish) begin
            pub_id   <= w_id;
            pub_prio <= w_prio;
            pub_nmi  <= w_nmi;
        end
    end

    // Old best survived unchallenged inside the walked range.
    assign need_full = !w_seen && (w_prio != PRIO_NONE) &&
                       (w_id >= range_lo) && (w_id <= range_hi);

    // R1: without a reinit the working priority can only become more urgent.
    a_r1_prio_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_full && !init_incr) |=> (w_prio <= $past(w_prio)));

    // R10: published record holds between completions.
    a_r10_pub_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !publish |=> ($stable(pub_prio) && $stable(pub_id) && $stable(pub_nmi)));
endmodule

// File: rtl/hppi_scanner.sv
// Highest-priority pending interrupt scanner.
// Walks IDs one per cycle, routes each eligible one to its target CPU slot,
// then compares LPI candidates and decides between publishing and a
// fallback full rescan. Assumes range_lo <= range_hi < NUM_IRQ and that the
// per-ID inputs answer combinationally to scan_id.
module hppi_scanner
    import hppi_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 3,
    localparam int ID_W  = $clog2(NUM_IRQ),
    localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      full_req,
    input  logic [ID_W-1:0]           range_lo,
    input  logic [ID_W-1:0]           range_hi,
    output logic                      busy,
    output logic                      done,
    output logic [ID_W-1:0]           scan_id,
    output logic                      mask_fetch,
    input  logic [CHUNK_W-1:0]        mask_in,
    input  logic [PRIO_W-1:0]         prio_in,
    input  logic                      nmi_in,
    input  logic                      group_in,
    input  logic [CPU_W-1:0]          tgt_in,
    input  logic                      tgt_valid_in,
    input  logic                      sec_disable,
    input  logic                      grp1ns_en,
    input  logic [NUM_CPU-1:0]        lpi_enable,
    input  logic [NUM_CPU*ID_W-1:0]   lpi_id,
    input  logic [NUM_CPU*PRIO_W-1:0] lpi_prio,
    input  logic [NUM_CPU-1:0]        lpi_nmi,
    output logic [NUM_CPU*ID_W-1:0]   best_id,
    output logic [NUM_CPU*PRIO_W-1:0] best_prio,
    output logic [NUM_CPU-1:0]        best_nmi,
    output logic [NUM_CPU-1:0]        best_valid
);
    localparam logic [ID_W-1:0] LAST_ID = ID_W'(NUM_IRQ - 1);

    scan_state_e       state;
    logic [ID_W-1:0]   lo_q, hi_q;
    logic              full_q;
    logic              done_q;
    logic [CHUNK_W-1:0] mask_q, mask_cur;
    logic              elig, tgt_ok;
    logic [PRIO_W-1:0] eff_prio;
    logic [NUM_CPU-1:0] need_full;
    logic              fallback, init_full, init_incr, publish;

    assign busy = (state != ST_IDLE);
    assign done = done_q;

    // Eligibility word: fetched at range start and at each 32-ID boundary.
    assign mask_fetch = (state == ST_SCAN) &&
                        ((scan_id == lo_q) || (scan_id[CHUNK_B-1:0] == '0));
    assign mask_cur   = mask_fetch ? mask_in : mask_q;
    assign elig       = mask_cur[scan_id[CHUNK_B-1:0]];
    assign tgt_ok     = tgt_valid_in && (int'(tgt_in) < NUM_CPU);

    // Scan controls shared by all slots.
    assign fallback  = (state == ST_CHECK) && !full_q && (|need_full);
    assign init_full = ((state == ST_IDLE) && start && full_req) || fallback;
    assign init_incr = (state == ST_IDLE) && start && !full_req;
    assign publish   = (state == ST_CHECK) && !fallback;

    hppi_prio_eval u_eval (
        .prio        (prio_in),
        .nmi         (nmi_in),
        .group_bit   (group_in),
        .sec_disable (sec_disable),
        .eff_prio    (eff_prio)
    );

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_cpu
        logic hit, lpi_ok;
        logic [ID_W-1:0]   p_id;
        logic [PRIO_W-1:0] p_prio;
        logic              p_nmi;

        assign hit    = (state == ST_SCAN) && elig && tgt_ok &&
                        (tgt_in == CPU_W'(g));
        assign lpi_ok = lpi_enable[g] && grp1ns_en &&
                        (lpi_prio[g*PRIO_W +: PRIO_W] != PRIO_NONE);

        hppi_cpu_slot #(.ID_W(ID_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .init_full (init_full),
            .init_incr (init_incr),
            .cand_en   (hit),
            .cand_id   (scan_id),
            .cand_prio (eff_prio),
            .cand_nmi  (nmi_in),
            .lpi_step  (state == ST_LPI),
            .lpi_ok    (lpi_ok),
            .lpi_id    (lpi_id[g*ID_W +: ID_W]),
            .lpi_prio  (lpi_prio[g*PRIO_W +: PRIO_W]),
            .lpi_nmi   (lpi_nmi[g]),
            .range_lo  (lo_q),
            .range_hi  (hi_q),
            .publish   (publish),
            .need_full (need_full[g]),
            .pub_id    (p_id),
            .pub_prio  (p_prio),
            .pub_nmi   (p_nmi)
        );

        assign best_id[g*ID_W +: ID_W]       = p_id;
        assign best_prio[g*PRIO_W +: PRIO_W] = p_prio;
        assign best_nmi[g]                   = p_nmi;
        assign best_valid[g]                 = (p_prio != PRIO_NONE);
    end

    // Hold the current eligibility word between fetches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_fetch) begin
            mask_q <= mask_in;
        end
    end

    // Sequencer: idle, walk IDs, LPI compare, completion check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            scan_id <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
            full_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        full_q  <= full_req;
                        lo_q    <= full_req ? '0 : range_lo;
                        hi_q    <= full_req ? LAST_ID : range_hi;
                        scan_id <= full_req ? '0 : range_lo;
                        state   <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (scan_id == hi_q) begin
                        state <= ST_LPI;
                    end else begin
                        scan_id <= scan_id + 1'b1;
                    end
                end
                ST_LPI: begin
                    state <= ST_CHECK;
                end
                ST_CHECK: begin
                    if (fallback) begin
                        full_q  <= 1'b1;
                        lo_q    <= '0;
                        hi_q    <= LAST_ID;
                        scan_id <= '0;
                        state   <= ST_SCAN;
                    end else begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R10: completion is a single-cycle pulse.
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: completion is reported only once the block is idle.
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10: one ID per cycle while walking.
    a_r10_one_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN && scan_id != hi_q) |=>
        (state == ST_SCAN && scan_id == $past(scan_id) + 1'b1));

    // R10: a start during a walk leaves the range untouched.
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SCAN || state == ST_LPI) && start) |=>
        ($stable(lo_q) && $stable(hi_q)));

    // R6: the first ID of every walk fetches a fresh word.
    a_r6_fetch_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> mask_fetch);
endmodule

// File: tb/tb_hppi_scanner.sv
module tb_hppi_scanner;
    localparam int CLK_PERIOD = 10;
    localparam int NIRQ = 64;
    localparam int NCPU = 3;
    localparam int IW   = 6;
    localparam int CW   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, full_req = 1'b0;
    logic [IW-1:0] range_lo = '0, range_hi = '0;
    logic busy, done, mask_fetch;
    logic [IW-1:0] scan_id;
    logic [31:0] mask_in;
    logic [7:0] prio_in;
    logic nmi_in, group_in, tgt_valid_in;
    logic [CW-1:0] tgt_in;
    logic sec_disable = 1'b0, grp1ns_en = 1'b1;
    logic [NCPU-1:0] lpi_enable, lpi_nmi;
    logic [NCPU*IW-1:0] lpi_id;
    logic [NCPU*8-1:0] lpi_prio;
    logic [NCPU*IW-1:0] best_id;
    logic [NCPU*8-1:0] best_prio;
    logic [NCPU-1:0] best_nmi, best_valid;

    always #(CLK_PERIOD/2) clk = ~clk;

    hppi_scanner #(.NUM_IRQ(NIRQ), .NUM_CPU(NCPU)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .full_req(full_req),
        .range_lo(range_lo), .range_hi(range_hi), .busy(busy), .done(done),
        .scan_id(scan_id), .mask_fetch(mask_fetch), .mask_in(mask_in),
        .prio_in(prio_in), .nmi_in(nmi_in), .group_in(group_in),
        .tgt_in(tgt_in), .tgt_valid_in(tgt_valid_in),
        .sec_disable(sec_disable), .grp1ns_en(grp1ns_en),
        .lpi_enable(lpi_enable), .lpi_id(lpi_id), .lpi_prio(lpi_prio),
        .lpi_nmi(lpi_nmi), .best_id(best_id), .best_prio(best_prio),
        .best_nmi(best_nmi), .best_valid(best_valid)
    );

    // Configuration held by the bench
    logic [7:0] pr [NIRQ];
    bit nm [NIRQ];
    bit gp [NIRQ];
    bit tv [NIRQ];
    int tg [NIRQ];
    logic [NIRQ-1:0] pend;
    bit l_en [NCPU];
    int l_id [NCPU];
    logic [7:0] l_pr [NCPU];
    bit l_nm [NCPU];

    // Expected records and their previous values
    int e_id [NCPU];
    int e_pr [NCPU];
    bit e_nm [NCPU];
    int p_id [NCPU];
    int p_pr [NCPU];
    bit p_nm [NCPU];
    bit seen_m [NCPU];

    int n_chk = 0, n_fail = 0, fetch_cnt = 0;

    always_comb begin
        prio_in      = pr[scan_id];
        nmi_in       = nm[scan_id];
        group_in     = gp[scan_id];
        tgt_valid_in = tv[scan_id];
        tgt_in       = CW'(tg[scan_id]);
        mask_in      = scan_id[5] ? pend[63:32] : pend[31:0];
        for (int c = 0; c < NCPU; c++) begin
            lpi_enable[c]       = l_en[c];
            lpi_nmi[c]          = l_nm[c];
            lpi_id[c*IW +: IW]  = IW'(l_id[c]);
            lpi_prio[c*8 +: 8]  = l_pr[c];
        end
    end

    always @(posedge clk) if (mask_fetch) fetch_cnt++;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Reference: effective priority and replacement rule
    function automatic int eff(int id);
        if (nm[id]) return (!sec_disable && gp[id]) ? 8'h80 : 8'h00;
        return int'(pr[id]);
    endfunction

    function automatic bit better(int c, int id, int p, bit n);
        if (p != e_pr[c]) return p < e_pr[c];
        if (n != e_nm[c]) return n;
        return id <= e_id[c];
    endfunction

    task automatic model_body(input int lo, input int hi);
        for (int id = lo; id <= hi; id++) begin
            if (pend[id] && tv[id] && tg[id] < NCPU) begin
                int c = tg[id];
                if (better(c, id, eff(id), nm[id])) begin
                    e_id[c] = id; e_pr[c] = eff(id); e_nm[c] = nm[id]; seen_m[c] = 1;
                end
            end
        end
        for (int c = 0; c < NCPU; c++) begin
            if (l_en[c] && grp1ns_en && l_pr[c] != 8'hFF &&
                better(c, l_id[c], int'(l_pr[c]), l_nm[c])) begin
                e_id[c] = l_id[c]; e_pr[c] = int'(l_pr[c]); e_nm[c] = l_nm[c]; seen_m[c] = 1;
            end
        end
    endtask

    task automatic model_full();
        for (int c = 0; c < NCPU; c++) begin
            e_pr[c] = 8'hFF; e_nm[c] = 0; seen_m[c] = 0;
        end
        model_body(0, NIRQ-1);
    endtask

    task automatic model_run(input bit f, input int lo, input int hi, output bit fb);
        fb = 0;
        if (f) begin
            model_full();
        end else begin
            for (int c = 0; c < NCPU; c++) seen_m[c] = 0;
            model_body(lo, hi);
            for (int c = 0; c < NCPU; c++)
                if (!seen_m[c] && e_pr[c] != 8'hFF && e_id[c] >= lo && e_id[c] <= hi) fb = 1;
            if (fb) model_full();
        end
    endtask

    function automatic int mult32(input int lo, input int hi);
        int n = 1;
        for (int i = lo + 1; i <= hi; i++) if (i % 32 == 0) n++;
        return n;
    endfunction

    task automatic cmp_out(input string rq);
        for (int c = 0; c < NCPU; c++) begin
            chk(best_valid[c] == (e_pr[c] != 8'hFF), rq, "valid", best_valid[c], e_pr[c] != 8'hFF);
            chk(int'(best_prio[c*8 +: 8]) == e_pr[c], rq, "prio", best_prio[c*8 +: 8], e_pr[c]);
            if (e_pr[c] != 8'hFF) begin
                chk(best_nmi[c] == e_nm[c], rq, "nmi", best_nmi[c], e_nm[c]);
                chk(int'(best_id[c*IW +: IW]) == e_id[c], rq, "id", best_id[c*IW +: IW], e_id[c]);
            end
        end
    endtask

    // One scan: model, drive, time it, compare. poke>0 re-pulses start mid-scan.
    task automatic run_op(input bit f, input int lo, input int hi,
                          input string rq, input int poke);
        bit fb;
        int cyc, exp_cyc, exp_fetch;
        for (int c = 0; c < NCPU; c++) begin
            p_id[c] = e_id[c]; p_pr[c] = e_pr[c]; p_nm[c] = e_nm[c];
        end
        model_run(f, lo, hi, fb);
        exp_cyc   = (f ? NIRQ : hi - lo + 1) + 2 + (fb ? NIRQ + 2 : 0);
        exp_fetch = (f ? 2 : mult32(lo, hi)) + (fb ? 2 : 0);
        @(negedge clk);
        start = 1; full_req = f; range_lo = IW'(lo); range_hi = IW'(hi);
        fetch_cnt = 0;
        @(negedge clk);
        start = 0;
        cyc = 0;
        // R10: published record unchanged while the scan is running
        for (int c = 0; c < NCPU; c++)
            chk(int'(best_prio[c*8 +: 8]) == p_pr[c], "R10", "hold prio",
                best_prio[c*8 +: 8], p_pr[c]);
        while (!done && cyc < 400) begin
            @(negedge clk);
            cyc++;
            if (poke > 0 && cyc == poke) begin
                start = 1; full_req = 0; range_lo = 1; range_hi = 1;
            end else begin
                start = 0;
            end
        end
        chk(cyc == exp_cyc, "R10", "cycles", cyc, exp_cyc);
        chk(fetch_cnt == exp_fetch, "R6", "fetches", fetch_cnt, exp_fetch);
        cmp_out(rq);
        @(negedge clk);
        chk(done == 0, "R10", "done width", done, 0);
    endtask

    task automatic clear_cfg();
        for (int i = 0; i < NIRQ; i++) begin
            pr[i] = 8'h40; nm[i] = 0; gp[i] = 0; tv[i] = 1; tg[i] = 0;
        end
        pend = '0;
        for (int c = 0; c < NCPU; c++) begin
            l_en[c] = 0; l_id[c] = 0; l_pr[c] = 8'hFF; l_nm[c] = 0;
        end
        sec_disable = 0; grp1ns_en = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        clear_cfg();
        for (int c = 0; c < NCPU; c++) begin
            e_id[c] = 0; e_pr[c] = 8'hFF; e_nm[c] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11: reset state
        chk(busy == 0 && done == 0, "R11", "busy/done", {busy, done}, 0);
        chk(best_valid == '0, "R11", "valid", best_valid, 0);
        chk(best_prio == {NCPU{8'hFF}}, "R11", "prio", best_prio, {NCPU{8'hFF}});

        // R5: nothing pending gives an invalid record
        run_op(1, 0, 0, "R5", 0);

        // R1: numerically lower priority wins
        pend[3] = 1; pr[3] = 8'd40; pend[10] = 1; pr[10] = 8'd20;
        run_op(1, 0, 0, "R1", 0);

        // R3: equal priority, lowest ID; then refresh by same ID
        clear_cfg();
        pend[7] = 1; pend[4] = 1; pr[7] = 8'd50; pr[4] = 8'd50;
        run_op(1, 0, 0, "R3", 0);
        run_op(0, 4, 4, "R3", 0);

        // R2: NMI beats plain interrupt at the same effective priority
        clear_cfg();
        pend[20] = 1; pr[20] = 8'h80; tg[20] = 1;
        pend[30] = 1; nm[30] = 1; gp[30] = 1; tg[30] = 1;
        run_op(1, 0, 0, "R2", 0);

        // R4: NMI synthesised priority under each setting
        sec_disable = 1;
        run_op(1, 0, 0, "R4", 0);
        sec_disable = 0; gp[30] = 0;
        run_op(1, 0, 0, "R4", 0);

        // R7: untargeted and out-of-range targets skipped
        clear_cfg();
        pend[5] = 1; pr[5] = 8'd1; tv[5] = 0;
        pend[6] = 1; pr[6] = 8'd1; tg[6] = 3;
        pend[9] = 1; pr[9] = 8'd100; tg[9] = 2;
        run_op(1, 0, 0, "R7", 0);

        // R9: LPI candidate gating
        l_id[2] = 40; l_pr[2] = 8'd10; l_en[2] = 0;
        run_op(1, 0, 0, "R9", 0);
        l_en[2] = 1; grp1ns_en = 0;
        run_op(1, 0, 0, "R9", 0);
        grp1ns_en = 1;
        run_op(1, 0, 0, "R9", 0);

        // R8: incremental keeps out-of-range best; falls back when it may drop
        clear_cfg();
        pend[10] = 1; pr[10] = 8'd30; pend[50] = 1; pr[50] = 8'd90;
        run_op(1, 0, 0, "R8", 0);
        pend[10] = 0;
        run_op(0, 20, 40, "R8", 0);
        run_op(0, 0, 15, "R8", 0);

        // R6: ranges crossing a 32-ID boundary
        pend[33] = 1; pr[33] = 8'd5; tg[33] = 1;
        run_op(0, 30, 35, "R6", 0);

        // R10: start while busy is ignored
        run_op(1, 0, 0, "R10", 5);

        // Sweep over random configurations, full and incremental
        for (int t = 0; t < 300; t++) begin
            int lo, hi;
            for (int i = 0; i < NIRQ; i++) begin
                pr[i] = 8'($urandom_range(0, 254));
                nm[i] = ($urandom_range(0, 7) == 0);
                gp[i] = $urandom_range(0, 1);
                tv[i] = ($urandom_range(0, 9) != 0);
                tg[i] = $urandom_range(0, 3);
                pend[i] = ($urandom_range(0, 5) == 0);
            end
            for (int c = 0; c < NCPU; c++) begin
                l_en[c] = $urandom_range(0, 1);
                l_id[c] = $urandom_range(0, NIRQ-1);
                l_pr[c] = 8'($urandom_range(0, 255));
                l_nm[c] = $urandom_range(0, 1);
            end
            sec_disable = $urandom_range(0, 1);
            grp1ns_en = $urandom_range(0, 1);
            lo = $urandom_range(0, NIRQ-1);
            hi = $urandom_range(lo, NIRQ-1);
            run_op(t % 2 == 0, lo, hi, "R1-sweep R2 R3 R4 R7 R8 R9", 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule